// File: doc/BRIEF.md
# Burst control word checker

This block sits on a 16-bit receive word stream in which control words and payload words are interleaved. A control word closes the burst before it and opens the burst after it. The block decodes each control word, tags every word with the port it belongs to and with its packet markers, and raises error flags when a control word breaks one of the framing rules. The rules cover a bad diagonal interleaved parity, a non-final burst whose length is not a whole number of 16-byte units, and a start of packet on a port that already has a packet open.

Words enter on a valid/ready stream and leave one cycle later on a valid/ready stream, carrying their annotation. A word is taken when `in_valid` and `in_ready` are both high on a rising clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer with no word lost or repeated. While `out_valid` is high and `out_ready` is low, every output holds its value.

A control word has bit 15 set. Bits 14:13 give the end status of the burst that just ended, bit 12 marks the start of a packet, bits 11:4 hold the port of the burst that follows, and bits 3:0 hold the parity. A payload word has bit 15 clear and carries two valid bytes.

Top module: `burst_ctl_checker`

## Requirements
- R1: A word with bit 15 set is a control word. On its output, out_is_ctrl is 1, out_port is bits 11:4 and out_sop is bit 12. A word with bit 15 clear is a payload word. On its output, out_is_ctrl, out_sop, out_eop and out_abort are 0, out_bytes is 2 and out_port is the port of the most recent control word (0 after reset). out_data always equals the accepted word.
- R2: in_ready equals (not out_valid) or out_ready. An accepted word appears on the outputs in the next cycle. A stalled output keeps its value until it is taken. Words leave in the order they were accepted, each exactly once.
- R3: On a control word, bits 14:13 decode as follows. 00: out_eop=0, out_abort=0, out_bytes=0. 01: out_eop=1, out_abort=1, out_bytes=0. 10: out_eop=1, out_abort=0, out_bytes=2. 11: out_eop=1, out_abort=0, out_bytes=1.
- R4: The parity is computed with a 16-bit accumulator, processing each word in order as acc = rotate-left-by-1(acc) XOR word. The control word enters this calculation with its bits 3:0 replaced by 1111. The expected parity is the XOR of the four nibbles of the result. out_dip_err is 1 on a control word exactly when this value differs from bits 3:0 of that word.
- R5: The accumulator is cleared after every control word and is zero after reset, so each check covers only the payload words since the previous control word (or since reset) plus the control word itself.
- R6: When a control word has bits 14:13 = 00 and the number of payload words since the previous control word is not a multiple of 8 (16 bytes), out_len_err is 1. On every control word, out_err_port is the port of the previous control word (0 after reset). On payload words, out_err_port equals out_port.
- R7: A control word with bits 14:13 other than 00 never raises out_len_err, whatever the burst length. A zero-length burst never raises it either.
- R8: Every port is closed after reset. A control word first closes the previous port when bits 14:13 are not 00. It then sets out_sop_err if bit 12 is set and the new port is still open. It then opens the new port if bit 12 is set.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Annotated word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 16 | The word as received |
| out_is_ctrl | output | 1 | Word is a control word |
| out_port | output | 8 | Port of the word (new port on control words) |
| out_sop | output | 1 | Start-of-packet marker of a control word |
| out_eop | output | 1 | Control word ends a packet (normal or abort) |
| out_abort | output | 1 | Control word ends a packet with abort |
| out_bytes | output | 2 | Valid bytes: 2 on payload, tail bytes on a control word |
| out_dip_err | output | 1 | Parity mismatch on this control word |
| out_len_err | output | 1 | Non-final burst not a multiple of 16 bytes |
| out_sop_err | output | 1 | Start of packet on an already open port |
| out_err_port | output | 8 | Port of the burst that this control word closed |

## Verification
The block has three pieces of hidden state: the parity accumulator, the word count modulo 8 and the table of open ports. A wrong accumulator shows up as a false or missing out_dip_err on the next control word. A wrong count shows up as a false or missing out_len_err on the next non-final control word. A stale table entry shows up as a wrong out_sop_err on the next start of packet for that port. Each of these errors becomes visible one cycle after the control word that exposes it is accepted. The sweep crosses every end code with burst lengths from 0 to 17 words, under both a free-running and a stalling consumer, so that every residue of the count meets every end code.

// File: rtl/burst_chk_pkg.sv
package burst_chk_pkg;
  localparam int WORD_W = 16;
  localparam int PORT_W = 8;
  localparam int DIP_W  = 4;

  typedef enum logic [1:0] {
    EOP_NONE  = 2'b00,
    EOP_ABORT = 2'b01,
    EOP_TWO   = 2'b10,
    EOP_ONE   = 2'b11
  } eop_code_e;

  // Field view of an incoming word (meaningful when is_ctrl is set).
  typedef struct packed {
    logic              is_ctrl;
    eop_code_e         eop;
    logic              sop;
    logic [PORT_W-1:0] port;
    logic [DIP_W-1:0]  dip;
  } word_fields_t;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              is_ctrl;
    logic [PORT_W-1:0] port;
    logic              sop;
    logic              eop;
    logic              abort;
    logic [1:0]        bytes;
    logic              dip_err;
    logic              len_err;
    logic              sop_err;
    logic [PORT_W-1:0] err_port;
  } annot_t;

  function automatic logic [WORD_W-1:0] rotl1(input logic [WORD_W-1:0] a);
    return {a[WORD_W-2:0], a[WORD_W-1]};
  endfunction

  function automatic logic [DIP_W-1:0] dip_fold(input logic [WORD_W-1:0] a);
    logic [DIP_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W / DIP_W; i++) r ^= a[i*DIP_W +: DIP_W];
    return r;
  endfunction
endpackage

// File: rtl/burst_dip_accum.sv
module burst_dip_accum
  import burst_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              is_ctrl,
  input  logic [WORD_W-1:0] word,
  output logic [DIP_W-1:0]  dip_calc
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] masked;
  logic [WORD_W-1:0] acc_next;

  always_comb begin
    masked = word;
    if (is_ctrl) masked[DIP_W-1:0] = '1;
    acc_next = rotl1(acc_q) ^ masked;
    dip_calc = dip_fold(acc_next);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= is_ctrl ? '0 : acc_next;
  end
endmodule

// File: rtl/burst_len_tracker.sv
module burst_len_tracker #(
  parameter int UNIT_WORDS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_data,
  input  logic step_ctrl,
  output logic misaligned
);
  localparam int CW = (UNIT_WORDS > 1) ? $clog2(UNIT_WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_WORDS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (step_ctrl) cnt_q <= '0;
    else if (step_data) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign misaligned = (cnt_q != '0);
endmodule

// File: rtl/burst_port_table.sv
module burst_port_table #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          close_en,
  input  logic [PW-1:0] close_port,
  input  logic          open_en,
  input  logic [PW-1:0] open_port,
  output logic          reopen_hit
);
  localparam int NP = 1 << PW;

  logic [NP-1:0] open_q;
  logic [NP-1:0] after_close;
  logic [NP-1:0] open_next;

  always_comb begin
    after_close = open_q;
    if (close_en) after_close[close_port] = 1'b0;
    reopen_hit = after_close[open_port];
    open_next = after_close;
    if (open_en) open_next[open_port] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    open_q <= '0;
    else if (step) open_q <= open_next;
  end
endmodule

// File: rtl/burst_ctl_checker.sv
module burst_ctl_checker
  import burst_chk_pkg::*;
#(
  parameter int UNIT_BYTES = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_is_ctrl,
  output logic [PORT_W-1:0] out_port,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_abort,
  output logic [1:0]        out_bytes,
  output logic              out_dip_err,
  output logic              out_len_err,
  output logic              out_sop_err,
  output logic [PORT_W-1:0] out_err_port
);
  localparam int UNIT_WORDS = UNIT_BYTES / WORD_BYTES;

  word_fields_t      fld;
  logic              fire;
  logic              step_data;
  logic              step_ctrl;
  logic              ends_pkt;
  logic [PORT_W-1:0] cur_port_q;
  logic [DIP_W-1:0]  dip_calc;
  logic              misaligned;
  logic              reopen_hit;
  annot_t            nxt;
  annot_t            out_q;
  logic              out_valid_q;

  assign fld       = word_fields_t'(in_data);
  assign in_ready  = !out_valid_q || out_ready;
  assign fire      = in_valid && in_ready;
  assign step_data = fire && !fld.is_ctrl;
  assign step_ctrl = fire && fld.is_ctrl;
  assign ends_pkt  = (fld.eop != EOP_NONE);

  burst_dip_accum u_dip (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (fire),
    .is_ctrl  (fld.is_ctrl),
    .word     (in_data),
    .dip_calc (dip_calc)
  );

  burst_len_tracker #(.UNIT_WORDS(UNIT_WORDS)) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_data  (step_data),
    .step_ctrl  (step_ctrl),
    .misaligned (misaligned)
  );

  burst_port_table #(.PW(PORT_W)) u_ports (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step_ctrl),
    .close_en   (ends_pkt),
    .close_port (cur_port_q),
    .open_en    (fld.sop),
    .open_port  (fld.port),
    .reopen_hit (reopen_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         cur_port_q <= '0;
    else if (step_ctrl) cur_port_q <= fld.port;
  end

  always_comb begin
    nxt          = '0;
    nxt.data     = in_data;
    nxt.is_ctrl  = fld.is_ctrl;
    nxt.err_port = cur_port_q;
    if (fld.is_ctrl) begin
      nxt.port    = fld.port;
      nxt.sop     = fld.sop;
      nxt.eop     = ends_pkt;
      nxt.abort   = (fld.eop == EOP_ABORT);
      unique case (fld.eop)
        EOP_TWO:  nxt.bytes = 2'd2;
        EOP_ONE:  nxt.bytes = 2'd1;
        default:  nxt.bytes = 2'd0;
      endcase
      nxt.dip_err = (dip_calc != fld.dip);
      nxt.len_err = !ends_pkt && misaligned;
      nxt.sop_err = fld.sop && reopen_hit;
    end else begin
      nxt.port  = cur_port_q;
      nxt.bytes = 2'(WORD_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else if (fire) begin
      out_valid_q <= 1'b1;
      out_q       <= nxt;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid    = out_valid_q;
  assign out_data     = out_q.data;
  assign out_is_ctrl  = out_q.is_ctrl;
  assign out_port     = out_q.port;
  assign out_sop      = out_q.sop;
  assign out_eop      = out_q.eop;
  assign out_abort    = out_q.abort;
  assign out_bytes    = out_q.bytes;
  assign out_dip_err  = out_q.dip_err;
  assign out_len_err  = out_q.len_err;
  assign out_sop_err  = out_q.sop_err;
  assign out_err_port = out_q.err_port;
endmodule

// File: rtl/burst_ctl_checker_sva.sv
module burst_ctl_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data,
  input logic        out_is_ctrl,
  input logic        out_sop,
  input logic        out_eop,
  input logic        out_abort,
  input logic [1:0]  out_bytes,
  input logic        out_dip_err,
  input logic        out_len_err,
  input logic        out_sop_err
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_ctrl)); // R2
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R2
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R2
  AST_PAYLOAD_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_ctrl |-> out_bytes == 2'd2 && !out_eop && !out_sop && !out_dip_err); // R1
  AST_ABORT_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_abort |-> out_eop && out_bytes == 2'd0); // R3
  AST_FINAL_NO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop |-> !out_len_err); // R7
  AST_LEN_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_len_err |-> out_is_ctrl); // R6
  AST_SOP_ERR_NEEDS_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop_err |-> out_sop && out_is_ctrl); // R8
endmodule

bind burst_ctl_checker burst_ctl_checker_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_is_ctrl (out_is_ctrl),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .out_abort   (out_abort),
  .out_bytes   (out_bytes),
  .out_dip_err (out_dip_err),
  .out_len_err (out_len_err),
  .out_sop_err (out_sop_err)
);

// File: tb/burst_ctl_checker_tb.sv
module burst_ctl_checker_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] data;
    logic        is_ctrl;
    logic [7:0]  port;
    logic        sop, eop, abort;
    logic [1:0]  bytes;
    logic        dip_err, len_err, sop_err;
    logic [7:0]  err_port;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [15:0] in_data = '0, out_data;
  logic out_is_ctrl, out_sop, out_eop, out_abort, out_dip_err, out_len_err, out_sop_err;
  logic [7:0] out_port, out_err_port;
  logic [1:0] out_bytes;

  int checks = 0, errors = 0;
  bit done = 0, stall_en = 0;
  logic [7:0] lfsr = 8'h5A;
  exp_t exp_q[$];
  logic [15:0] m_acc = '0;
  int m_cnt = 0;
  logic [7:0] m_port = '0;
  logic [255:0] m_open = '0;
  bit held = 0;
  logic [15:0] held_data;

  burst_ctl_checker u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_is_ctrl(out_is_ctrl),
    .out_port(out_port), .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort),
    .out_bytes(out_bytes), .out_dip_err(out_dip_err), .out_len_err(out_len_err),
    .out_sop_err(out_sop_err), .out_err_port(out_err_port)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rot(input logic [15:0] a);
    return {a[14:0], a[15]};
  endfunction
  function automatic logic [3:0] fold(input logic [15:0] a);
    return a[15:12] ^ a[11:8] ^ a[7:4] ^ a[3:0];
  endfunction

  // Build a control word whose parity matches the model, then xor a corruption mask (R4).
  function automatic logic [15:0] mk_ctrl(input logic [1:0] code, input logic sop,
                                          input logic [7:0] port, input logic [3:0] bad);
    logic [15:0] w;
    w = {1'b1, code, sop, port, 4'h0};
    w[3:0] = fold(rot(m_acc) ^ {w[15:4], 4'hF}) ^ bad;
    return w;
  endfunction

  task automatic send(input logic [15:0] w);
    exp_t e;
    e = '0;
    e.data = w;
    if (!w[15]) begin
      m_acc = rot(m_acc) ^ w;
      m_cnt++;
      e.port = m_port; e.bytes = 2'd2; e.err_port = m_port;
    end else begin
      e.is_ctrl  = 1'b1;
      e.dip_err  = fold(rot(m_acc) ^ {w[15:4], 4'hF}) != w[3:0];
      e.len_err  = (w[14:13] == 2'b00) && (m_cnt % 8 != 0);
      e.err_port = m_port;
      e.eop      = (w[14:13] != 2'b00);
      e.abort    = (w[14:13] == 2'b01);
      e.bytes    = (w[14:13] == 2'b10) ? 2'd2 : (w[14:13] == 2'b11) ? 2'd1 : 2'd0;
      if (e.eop) m_open[m_port] = 1'b0;
      e.sop      = w[12];
      e.port     = w[11:4];
      e.sop_err  = w[12] && m_open[w[11:4]];
      if (w[12]) m_open[w[11:4]] = 1'b1;
      m_port = w[11:4]; m_acc = '0; m_cnt = 0;
    end
    exp_q.push_back(e);
    @(negedge clk); #1;
    in_valid = 1'b1; in_data = w;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk); #1; in_valid = 1'b0;
  endtask

  task automatic burst(input logic [1:0] code, input logic [7:0] port, input int len, input int k);
    send(mk_ctrl(2'b00, 1'b1, port, 4'h0));
    for (int i = 0; i < len; i++) send({1'b0, 15'(k * 37 + i * 11 + 3)});
    send(mk_ctrl(code, 1'b0, port, (k % 5 == 4) ? 4'(1 << (k % 4)) : 4'h0));
  endtask

  // Output monitor: consumer pattern, order/content compare, stall hold (R2).
  always @(negedge clk) begin
    exp_t e, got;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (held) begin
      checks++;
      if (!out_valid || out_data !== held_data) begin
        errors++;
        $display("FAIL R2 stalled word changed: got valid=%0b data=%h expected data=%h", out_valid, out_data, held_data);
      end
    end
    out_ready = !stall_en || lfsr[0] || lfsr[2];
    held = rst_n && out_valid && !out_ready;
    held_data = out_data;
    if (rst_n && out_valid && out_ready) begin
      got = {out_data, out_is_ctrl, out_port, out_sop, out_eop, out_abort, out_bytes,
             out_dip_err, out_len_err, out_sop_err, out_err_port};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 extra word: got %h expected none", out_data);
      end else begin
        e = exp_q.pop_front();
        if (got !== e) begin
          errors++;
          if (got.data !== e.data || got.is_ctrl !== e.is_ctrl || got.port !== e.port || got.sop !== e.sop)
            $display("FAIL R1/R2 word fields: got %h expected %h", got, e);
          else if (got.eop !== e.eop || got.abort !== e.abort || got.bytes !== e.bytes)
            $display("FAIL R3 end decode: got %h expected %h", got, e);
          else if (got.dip_err !== e.dip_err)
            $display("FAIL R4 R5 parity flag: got %0b expected %0b (word %h)", got.dip_err, e.dip_err, e.data);
          else if (got.len_err !== e.len_err || got.err_port !== e.err_port)
            $display("FAIL R6 R7 length flag/port: got %0b/%h expected %0b/%h", got.len_err, got.err_port, e.len_err, e.err_port);
          else
            $display("FAIL R8 sop flag: got %0b expected %0b", got.sop_err, e.sop_err);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9 reset: got valid=%0b ready=%0b expected 0/1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    // Payload before any control word: counted against port 0 (R5, R6).
    for (int i = 0; i < 3; i++) send(16'h0100 + 16'(i));
    send(mk_ctrl(2'b00, 1'b0, 8'd0, 4'h0));
    // Sweep every end code against lengths 0..17, free-running then stalling (R1, R3, R4, R6, R7).
    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int code = 0; code < 4; code++)
        for (int len = 0; len < 18; len++)
          burst(2'(code), 8'(100 + pass * 80 + code * 18 + len), len, pass * 72 + code * 18 + len);
      // Close every port left open so the second pass starts clean (R8).
      for (int p = 0; p < 256; p++)
        if (m_open[p]) begin
          send(mk_ctrl(2'b00, 1'b0, 8'(p), 4'h0));
          send(mk_ctrl(2'b01, 1'b0, 8'(p), 4'h0));
        end
    end
    go_idle();
    // R8: reopen without close, then close-and-reopen in the same word.
    send(mk_ctrl(2'b00, 1'b1, 8'd5, 4'h0));
    for (int i = 0; i < 8; i++) send(16'h0200 + 16'(i));
    send(mk_ctrl(2'b00, 1'b1, 8'd5, 4'h0));
    for (int i = 0; i < 3; i++) send(16'h0300 + 16'(i));
    send(mk_ctrl(2'b11, 1'b1, 8'd5, 4'h0));
    send(mk_ctrl(2'b10, 1'b1, 8'd7, 4'hF));
    go_idle();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule